// File: doc/BRIEF.md
# MDIO Management Master

This block is a bus master for the two-wire station management interface used to configure Ethernet PHYs. A host reaches it through a small word-addressed register port. The host loads an address word and a write-data word, then writes a command word with its go bit set. The block then sends exactly one management frame on the MDC/MDIO pair. For read frames it samples the reply from the PHY and keeps it for the host to collect.

Both the IEEE 802.3 Clause 22 and Clause 45 frame formats are produced. The Clause 45 operations are address, write, read and read-with-post-increment. The frame type and opcode fields are copied onto the wire as given. Multi-frame Clause 45 sequences are up to software: it issues them one frame at a time and polls the go bit between frames.

MDC is derived from the system clock by a divider whose half-period is a parameter. MDIO changes only when MDC falls and is sampled when MDC rises.

Top module: `mdio_master`

## Requirements
- R1: After reset the command, status and read-data registers read 0, MDC is low and the MDIO output enable is low.
- R2: A register write to byte offset 0x0 with bit 14 set, made while bit 14 reads 0, starts one frame. Bit 14 then reads 1 until the frame ends, and the frame lasts exactly 64 MDC periods.
- R3: Frame bits go out MSB first in this order: 32 ones, then command bits [13:12] (frame type: 0 = Clause 45, 1 = Clause 22), bits [11:10] (opcode), bits [9:5] (port address), bits [4:0] (device/register address), a 2-bit turnaround and 16 data bits.
- R4: Write frames take their 16 data bits from the low half of the write-data register at offset 0x8, and drive the turnaround as 1 then 0. A write frame is Clause 22 opcode 1 or Clause 45 opcode 1.
- R5: A Clause 45 address frame (type 0, opcode 0) takes its data bits from the low half of the address register at offset 0x4.
- R6: Read frames are Clause 22 opcode 2 and Clause 45 opcodes 2 and 3. In a read frame the master releases MDIO (output enable low) from the first turnaround bit to the end. The 16 bits sampled in the data phase appear in the low half of the read-data register at offset 0xC when the frame ends.
- R7: Status bit 0 at offset 0x10 is set when MDIO is high at the second turnaround bit of a read. It is cleared when the next frame starts, and a good read leaves it at 0.
- R8: A command write while bit 14 reads 1 is ignored: the stored command fields do not change and no extra frame is sent.
- R9: MDC is low whenever no frame runs, its period is 2×MDC_HALF system clocks, and MDIO changes only at falling MDC edges.
- R10: Offsets 0x4 and 0x8 read back their low 16 bits; writes to offsets 0xC and 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data of the addressed register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | High when the master drives MDIO |
| mdio_i | input | 1 | MDIO line value as seen at the pin |

## Verification
The case hardest to reach from the ports is a read whose second turnaround bit comes back high. It needs a PHY that fails to answer at exactly one MDC rising edge. The bench models the PHY by counting MDC rising edges. It shifts a prepared response onto the line at each falling edge, so a vector can place a 1 in that single turnaround slot. The bench then runs a good write frame afterwards to show the flag clears. A command written while a frame is still shifting is the other hard case; it is issued a few cycles after a start, and the bench then counts the MDC edges that follow.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    typedef struct packed {
        logic [1:0] ftype;
        logic [1:0] opc;
        logic [4:0] port;
        logic [4:0] dev;
    } mdio_cmd_t;

    localparam logic [4:0] OFS_CMD  = 5'h00;
    localparam logic [4:0] OFS_ADDR = 5'h04;
    localparam logic [4:0] OFS_WDAT = 5'h08;
    localparam logic [4:0] OFS_RDAT = 5'h0C;
    localparam logic [4:0] OFS_STAT = 5'h10;
    localparam int GO_BIT = 14;

    function automatic logic is_read(mdio_cmd_t c);
        return (c.ftype == 2'd0) ? c.opc[1] : (c.opc == 2'd2);
    endfunction

    function automatic logic is_addr_frame(mdio_cmd_t c);
        return (c.ftype == 2'd0) && (c.opc == 2'd0);
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_t;

    gen_t st_d, st_q;
    logic wrap;

    assign wrap     = (st_q.cnt == CW'(MDC_HALF - 1));
    assign rise_stb = run && wrap && !st_q.mdc;
    assign fall_stb = run && wrap &&  st_q.mdc;
    assign mdc      = st_q.mdc;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic [15:0] word,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data,
    output logic        rd_done,
    output logic        rd_fail
);
    localparam int FLEN = PRE_LEN + 32;
    localparam int CW   = $clog2(FLEN);
    localparam int TA1  = PRE_LEN + 14;
    localparam int TA2  = PRE_LEN + 15;

    typedef struct packed {
        logic            busy;
        logic            rd;
        logic            fail;
        logic [CW-1:0]   cnt;
        logic [FLEN-1:0] sh;
        logic [15:0]     rsh;
    } eng_t;

    eng_t st_d, st_q;
    logic last;

    assign last    = (st_q.cnt == CW'(FLEN - 1));
    assign busy    = st_q.busy;
    assign mdio_o  = st_q.sh[FLEN-1];
    assign mdio_oe = st_q.busy && !(st_q.rd && (st_q.cnt >= CW'(TA1)));
    assign rd_data = st_q.rsh;
    assign rd_fail = st_q.fail;
    assign rd_done = st_q.busy && st_q.rd && fall_stb && last;

    always_comb begin
        st_d = st_q;
        if (start && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.rd   = is_read(cmd);
            st_d.fail = 1'b0;
            st_d.cnt  = '0;
            st_d.sh   = {{PRE_LEN{1'b1}}, cmd,
                         (is_read(cmd) ? 2'b11 : 2'b10),
                         (is_read(cmd) ? 16'hFFFF : word)};
        end else if (st_q.busy) begin
            if (rise_stb) begin
                if (st_q.rd && (st_q.cnt == CW'(TA2)) && mdio_i)
                    st_d.fail = 1'b1;
                if (st_q.cnt > CW'(TA2))
                    st_d.rsh = {st_q.rsh[14:0], mdio_i};
            end
            if (fall_stb) begin
                st_d.sh = {st_q.sh[FLEN-2:0], 1'b1};
                if (last) st_d.busy = 1'b0;
                else      st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    mdio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !fall_stb) |=> $stable(mdio_o));
    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !mdio_oe);
    // R7
    fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> !st_q.fail);
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 4,
    parameter int PRE_LEN  = 32,
    parameter int ADDR_W   = 5,
    parameter int REG_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    typedef struct packed {
        mdio_cmd_t   cmd;
        logic [15:0] addr;
        logic [15:0] wdat;
        logic [15:0] rdat;
    } regs_t;

    regs_t rg_d, rg_q;
    logic busy, rise_stb, fall_stb, rd_done, rd_fail, start, wr;
    logic [15:0] rd_data, frame_word;
    mdio_cmd_t new_cmd;
    logic unused_bits;

    assign unused_bits = ^bus_wdata[REG_W-1:16] ^ bus_wdata[15];
    assign wr      = bus_en && bus_we;
    assign new_cmd = mdio_cmd_t'(bus_wdata[13:0]);
    assign start   = wr && (bus_addr == ADDR_W'(OFS_CMD)) && bus_wdata[GO_BIT] && !busy;
    assign frame_word = is_addr_frame(new_cmd) ? rg_q.addr : rg_q.wdat;

    always_comb begin
        rg_d = rg_q;
        if (wr) begin
            unique case (bus_addr)
                ADDR_W'(OFS_CMD):  if (!busy) rg_d.cmd = new_cmd;
                ADDR_W'(OFS_ADDR): rg_d.addr = bus_wdata[15:0];
                ADDR_W'(OFS_WDAT): rg_d.wdat = bus_wdata[15:0];
                default: ;
            endcase
        end
        if (rd_done) rg_d.rdat = rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_CMD):  bus_rdata = REG_W'({busy, rg_q.cmd});
            ADDR_W'(OFS_ADDR): bus_rdata = REG_W'(rg_q.addr);
            ADDR_W'(OFS_WDAT): bus_rdata = REG_W'(rg_q.wdat);
            ADDR_W'(OFS_RDAT): bus_rdata = REG_W'(rg_q.rdat);
            ADDR_W'(OFS_STAT): bus_rdata = REG_W'(rd_fail);
            default: ;
        endcase
    end

    mdio_mdc_gen #(.MDC_HALF(MDC_HALF)) u_gen (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb));

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(new_cmd),
        .word(frame_word), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rd_data(rd_data), .rd_done(rd_done), .rd_fail(rd_fail));

    // R8
    cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr && (bus_addr == ADDR_W'(OFS_CMD))) |=> $stable(rg_q.cmd));
    // R9
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, line;
    logic        phy_drv = 1'b1;
    logic [63:0] phy_bits = '1;
    logic [63:0] cap = '0, capoe = '0;
    int          idx = 0;
    int          checks = 0, errors = 0;
    realtime     t_last = 0, t_per = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    assign line = mdio_oe ? mdio_o : phy_drv;

    mdio_master #(.MDC_HALF(HALF)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line));

    always @(posedge mdc) begin
        if (idx < 64) begin
            cap[63-idx]   = line;
            capoe[63-idx] = mdio_oe;
        end
        idx++;
        t_per  = $realtime - t_last;
        t_last = $realtime;
    end

    always @(negedge mdc) phy_drv = (idx < 64) ? phy_bits[63-idx] : 1'b1;

    // st(2) op(2) port(5) dev(5) addr(16) wdata(16) resp(16) fail(1)
    localparam logic [62:0] VEC [7] = '{
        {2'd1, 2'd1, 5'h03, 5'h11, 16'h0000, 16'hA5C3, 16'h0000, 1'b0},
        {2'd1, 2'd2, 5'h1F, 5'h00, 16'h0000, 16'h0000, 16'h1234, 1'b0},
        {2'd0, 2'd0, 5'h02, 5'h07, 16'hBEEF, 16'h5555, 16'h0000, 1'b0},
        {2'd0, 2'd1, 5'h0A, 5'h1E, 16'h1111, 16'h0F0F, 16'h0000, 1'b0},
        {2'd0, 2'd3, 5'h15, 5'h03, 16'h2222, 16'h0000, 16'hCAFE, 1'b0},
        {2'd0, 2'd2, 5'h01, 5'h1F, 16'h3333, 16'h0000, 16'h8001, 1'b0},
        {2'd1, 2'd2, 5'h04, 5'h02, 16'h0000, 16'h0000, 16'hFFFF, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int n = 0; n < 4000; n++) begin
            rd(5'h00, v);
            if (!v[14]) break;
        end
    endtask

    task automatic launch(input logic [62:0] v);
        logic [31:0] r;
        phy_bits = v[0] ? {{46{1'b1}}, 1'b1, 1'b1, v[16:1]}
                        : {{46{1'b1}}, 1'b1, 1'b0, v[16:1]};
        idx = 0;
        phy_drv = 1'b1;
        wr(5'h04, {16'h0, v[48:33]});
        wr(5'h08, {16'h0, v[32:17]});
        wr(5'h00, {17'h0, 1'b1, v[62:49]});
        rd(5'h00, r);
        chk("R2 busy after start", r[14], 1'b1);
    endtask

    initial begin
        logic [31:0] r;
        logic [63:0] fexp, oexp;
        logic        rdf;
        repeat (5) @(posedge clk);
        #1 chk("R1 mdc low", mdc, 1'b0);
        chk("R1 oe low", mdio_oe, 1'b0);
        rst_n = 1'b1;
        rd(5'h00, r); chk("R1 cmd reset", r, 32'h0);
        rd(5'h10, r); chk("R1 status reset", r, 32'h0);
        rd(5'h0C, r); chk("R1 rdata reset", r, 32'h0);

        for (int i = 0; i < 7; i++) begin
            logic [62:0] v;
            logic [15:0] dat;
            v = VEC[i];
            rdf = (v[62:61] == 2'd0) ? v[60] : (v[60:59] == 2'd2);
            if (rdf) dat = v[16:1];
            else if (v[62:59] == 4'd0) dat = v[48:33];
            else dat = v[32:17];
            fexp = {32'hFFFF_FFFF, v[62:49], (rdf ? {1'b1, v[0]} : 2'b10), dat};
            oexp = rdf ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
            launch(v);
            wait_idle();
            chk("R3 R4 R5 frame bits", cap, fexp);
            chk("R6 output enable pattern", capoe, oexp);
            chk("R2 64 MDC periods", idx, 64);
            if (rdf) begin
                rd(5'h0C, r); chk("R6 read data", r, {16'h0, v[16:1]});
                rd(5'h10, r); chk("R7 read status", r, {31'h0, v[0]});
            end
        end

        // R7: status cleared by next frame
        launch({2'd1, 2'd1, 5'h06, 5'h06, 16'h0, 16'h00FF, 16'h0, 1'b0});
        rd(5'h10, r); chk("R7 status cleared at start", r, 32'h0);
        wait_idle();
        chk("R9 MDC period", longint'(t_per * 1000.0), longint'(2 * HALF * 5 * 1000));
        #1 chk("R9 mdc idle low", mdc, 1'b0);

        // R8: command while busy ignored
        launch({2'd1, 2'd1, 5'h09, 5'h0C, 16'h0, 16'h1357, 16'h0, 1'b0});
        repeat (3) @(negedge clk);
        wr(5'h00, {17'h0, 1'b1, 2'd0, 2'd3, 5'h1A, 5'h01});
        wait_idle();
        repeat (400) @(negedge clk);
        rd(5'h00, r); chk("R8 fields kept", r, {18'h0, 2'd1, 2'd1, 5'h09, 5'h0C});
        chk("R8 single frame", idx, 64);
        chk("R8 frame unchanged", cap, {32'hFFFF_FFFF, 2'd1, 2'd1, 5'h09, 5'h0C, 2'b10, 16'h1357});

        // R10: offsets and read-only registers
        rd(5'h04, r); chk("R10 addr readback", r, 32'h0000_0000);
        wr(5'h04, 32'hABCD_9876);
        rd(5'h04, r); chk("R10 addr low half", r, 32'h0000_9876);
        rd(5'h08, r); chk("R10 wdata readback", r, 32'h0000_1357);
        wr(5'h0C, 32'h0000_0000);
        rd(5'h0C, r); chk("R10 rdata read-only", r, 32'h0000_FFFF);
        wr(5'h10, 32'h0000_0001);
        rd(5'h10, r); chk("R10 status read-only", r, 32'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule